// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block sequences the signal lamps at a crossing where road A meets road B. Each road has a vehicle sensor that reads high while cars are waiting or passing. The controller keeps the green on one road for as long as that road's sensor stays high. When the sensor drops, that road shows yellow for exactly one clock cycle. The green then passes to the other road, which shows red while the first road has green or yellow.

The controller is a Moore machine with four named states:

- `PH_A_GO`: road A green, road B red.
- `PH_A_WARN`: road A yellow, road B red.
- `PH_B_GO`: road A red, road B green.
- `PH_B_WARN`: road A red, road B yellow.

It has four named transitions:

- `A_HOLD`: `PH_A_GO` to `PH_A_GO`.
- `A_RELEASE`: `PH_A_GO` to `PH_A_WARN`.
- `A_HANDOVER`: `PH_A_WARN` to `PH_B_GO`.
- `B_HOLD`, `B_RELEASE` and `B_HANDOVER` mirror these for road B. `B_HANDOVER` returns to `PH_A_GO`.

The parameter `ONE_HOT` chooses how the state is stored:

- `ONE_HOT=0` stores a two-bit binary code.
- `ONE_HOT=1` stores four one-hot flops.

The lamp sequence at the outputs is the same for both. The stored state is visible on a four-bit debug port.

Top module: `crossing_light_fsm`

## Requirements
- R1: Reset is synchronous and active high. On any edge where `rst` is 1, the next state is `PH_A_GO` whatever the current state and sensors are. The cycle after reset shows A green and B red.
- R2: Lamp codes are green = 2'b00, yellow = 2'b01 and red = 2'b10. The code 2'b11 never appears on either lamp output.
- R3: In `PH_A_GO` with `sense_a` = 1, the machine stays in `PH_A_GO` (`A_HOLD`). `sense_b` has no effect there.
- R4: In `PH_A_GO` with `sense_a` = 0, the next state is `PH_A_WARN` (`A_RELEASE`). `sense_b` has no effect.
- R5: `PH_A_WARN` always moves to `PH_B_GO` on the next edge (`A_HANDOVER`), whatever the sensors show.
- R6: In `PH_B_GO` with `sense_b` = 1, the machine stays in `PH_B_GO` (`B_HOLD`). `sense_a` has no effect there.
- R7: In `PH_B_GO` with `sense_b` = 0, the next state is `PH_B_WARN` (`B_RELEASE`).
- R8: `PH_B_WARN` always moves to `PH_A_GO` on the next edge (`B_HANDOVER`).
- R9: The lamps depend only on the current state:
  - `PH_A_GO`: A green, B red.
  - `PH_A_WARN`: A yellow, B red.
  - `PH_B_GO`: A red, B green.
  - `PH_B_WARN`: A red, B yellow.
- R10: `dbg_state` shows the stored state:
  - With `ONE_HOT`=0, it shows the binary index (`PH_A_GO`=0, `PH_A_WARN`=1, `PH_B_GO`=2, `PH_B_WARN`=3) in bits [1:0], with bits [3:2] at 0.
  - With `ONE_HOT`=1, it shows a single 1 at bit position equal to that index.
- R11: For the same stimulus, the two encodings produce identical lamp sequences, cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to `PH_A_GO` |
| sense_a | input | 1 | Road A vehicle sensor, high when traffic is present |
| sense_b | input | 1 | Road B vehicle sensor, high when traffic is present |
| lamp_a | output | 2 | Road A lamp code (00 green, 01 yellow, 10 red) |
| lamp_b | output | 2 | Road B lamp code (00 green, 01 yellow, 10 red) |
| dbg_state | output | 4 | Stored state, binary or one-hot per `ONE_HOT` |

## Verification
Reset and an ordinary transition can fall on the same edge. The sharpest case is reset arriving while the machine is in `PH_A_WARN` or `PH_B_WARN`, where the step would otherwise be unconditional. The bench asserts reset in those states, and in `PH_B_GO` with both sensors high. It also applies reset at random through a long run of random sensor patterns. The outcome is judged by a reference model of the transition table: it must show `PH_A_GO` lamps and debug code on the following cycle rather than the successor state. Both encodings run side by side so that their lamp outputs can be compared every cycle.

// File: rtl/xing_pkg.sv
package xing_pkg;

    typedef enum logic [1:0] {
        LAMP_GO   = 2'b00,
        LAMP_WARN = 2'b01,
        LAMP_STOP = 2'b10
    } lamp_t;

    typedef enum logic [1:0] {
        PH_A_GO   = 2'd0,
        PH_A_WARN = 2'd1,
        PH_B_GO   = 2'd2,
        PH_B_WARN = 2'd3
    } phase_t;

    localparam int NUM_PHASES = 4;
    localparam int DBG_W      = NUM_PHASES;

endpackage

// File: rtl/xing_next.sv
module xing_next
    import xing_pkg::*;
(
    input  phase_t cur,
    input  logic   sense_a,
    input  logic   sense_b,
    output phase_t nxt
);

    // Next-state table: hold green on a busy road, one yellow cycle on release
    always_comb begin
        nxt = PH_A_GO;
        unique case (cur)
            PH_A_GO:   nxt = sense_a ? PH_A_GO : PH_A_WARN;   // A_HOLD / A_RELEASE
            PH_A_WARN: nxt = PH_B_GO;                          // A_HANDOVER
            PH_B_GO:   nxt = sense_b ? PH_B_GO : PH_B_WARN;   // B_HOLD / B_RELEASE
            PH_B_WARN: nxt = PH_A_GO;                          // B_HANDOVER
        endcase
    end

endmodule

// File: rtl/xing_state_reg.sv
module xing_state_reg
    import xing_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
)(
    input  logic               clk,
    input  logic               rst,
    input  phase_t             nxt,
    output phase_t             cur,
    output logic [DBG_W-1:0]   code
);

    localparam int BIN_W = $clog2(NUM_PHASES);

    generate
        if (ONE_HOT) begin : g_onehot
            logic [NUM_PHASES-1:0] oh_q;

            always_ff @(posedge clk) begin
                if (rst) oh_q <= NUM_PHASES'(1);
                else     oh_q <= NUM_PHASES'(1) << nxt;
            end

            always_comb begin
                case (oh_q)
                    4'b0010: cur = PH_A_WARN;
                    4'b0100: cur = PH_B_GO;
                    4'b1000: cur = PH_B_WARN;
                    default: cur = PH_A_GO;
                endcase
            end

            assign code = oh_q;
        end else begin : g_binary
            logic [BIN_W-1:0] bin_q;

            always_ff @(posedge clk) begin
                if (rst) bin_q <= BIN_W'(PH_A_GO);
                else     bin_q <= BIN_W'(nxt);
            end

            assign cur  = phase_t'(bin_q);
            assign code = DBG_W'(bin_q);
        end
    endgenerate

endmodule

// File: rtl/xing_lamps.sv
module xing_lamps
    import xing_pkg::*;
(
    input  phase_t cur,
    output lamp_t  lamp_a,
    output lamp_t  lamp_b
);

    // Moore output decode: lamps are a function of the phase only
    always_comb begin
        lamp_a = LAMP_GO;
        lamp_b = LAMP_STOP;
        unique case (cur)
            PH_A_GO:   begin lamp_a = LAMP_GO;   lamp_b = LAMP_STOP; end
            PH_A_WARN: begin lamp_a = LAMP_WARN; lamp_b = LAMP_STOP; end
            PH_B_GO:   begin lamp_a = LAMP_STOP; lamp_b = LAMP_GO;   end
            PH_B_WARN: begin lamp_a = LAMP_STOP; lamp_b = LAMP_WARN; end
        endcase
    end

endmodule

// File: rtl/crossing_light_fsm.sv
module crossing_light_fsm
    import xing_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       sense_a,
    input  logic       sense_b,
    output logic [1:0] lamp_a,
    output logic [1:0] lamp_b,
    output logic [3:0] dbg_state
);

    phase_t phase_cur;
    phase_t phase_nxt;
    lamp_t  la;
    lamp_t  lb;

    xing_next u_next (
        .cur     (phase_cur),
        .sense_a (sense_a),
        .sense_b (sense_b),
        .nxt     (phase_nxt)
    );

    xing_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
        .clk  (clk),
        .rst  (rst),
        .nxt  (phase_nxt),
        .cur  (phase_cur),
        .code (dbg_state)
    );

    xing_lamps u_lamps (
        .cur    (phase_cur),
        .lamp_a (la),
        .lamp_b (lb)
    );

    assign lamp_a = la;
    assign lamp_b = lb;

endmodule

// File: rtl/xing_checks.sv
module xing_checks #(
    parameter bit ONE_HOT = 1'b0
)(
    input logic       clk,
    input logic       rst,
    input logic       sense_a,
    input logic       sense_b,
    input logic [1:0] lamp_a,
    input logic [1:0] lamp_b,
    input logic [3:0] dbg_state
);

    localparam logic [1:0] GRN = 2'b00;
    localparam logic [1:0] YEL = 2'b01;
    localparam logic [1:0] RED = 2'b10;

    a_r1_reset_to_a_green: assert property (@(posedge clk)
        rst |=> (lamp_a == GRN && lamp_b == RED));

    a_r2_no_code_11: assert property (@(posedge clk) disable iff (rst)
        (lamp_a != 2'b11 && lamp_b != 2'b11));

    a_r9_one_road_red: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == RED || lamp_b == RED));

    a_r3_a_hold: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == GRN && sense_a) |=> (lamp_a == GRN));

    a_r4_a_release: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == GRN && !sense_a) |=> (lamp_a == YEL && lamp_b == RED));

    a_r5_a_handover: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == YEL) |=> (lamp_a == RED && lamp_b == GRN));

    a_r6_b_hold: assert property (@(posedge clk) disable iff (rst)
        (lamp_b == GRN && sense_b) |=> (lamp_b == GRN));

    a_r7_b_release: assert property (@(posedge clk) disable iff (rst)
        (lamp_b == GRN && !sense_b) |=> (lamp_b == YEL && lamp_a == RED));

    a_r8_b_handover: assert property (@(posedge clk) disable iff (rst)
        (lamp_b == YEL) |=> (lamp_a == GRN && lamp_b == RED));

    generate
        if (ONE_HOT) begin : g_oh_chk
            a_r10_onehot_code: assert property (@(posedge clk) disable iff (rst)
                ($countones(dbg_state) == 1));
        end else begin : g_bin_chk
            a_r10_binary_code: assert property (@(posedge clk) disable iff (rst)
                (dbg_state[3:2] == 2'b00));
        end
    endgenerate

endmodule

bind crossing_light_fsm xing_checks #(.ONE_HOT(ONE_HOT)) u_xing_checks (
    .clk       (clk),
    .rst       (rst),
    .sense_a   (sense_a),
    .sense_b   (sense_b),
    .lamp_a    (lamp_a),
    .lamp_b    (lamp_b),
    .dbg_state (dbg_state)
);

// File: tb/tb_crossing_light_fsm.sv
`timescale 1ns/1ps
module tb_crossing_light_fsm;

    logic       clk = 1'b0;
    logic       rst;
    logic       sense_a;
    logic       sense_b;
    logic [1:0] la_b, lb_b, la_o, lb_o;
    logic [3:0] dbg_b, dbg_o;

    int vectors = 0;
    int errors  = 0;
    int model   = 0;   // 0 A go, 1 A warn, 2 B go, 3 B warn
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    crossing_light_fsm #(.ONE_HOT(1'b0)) dut (
        .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
        .lamp_a(la_b), .lamp_b(lb_b), .dbg_state(dbg_b));

    crossing_light_fsm #(.ONE_HOT(1'b1)) dut_onehot (
        .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
        .lamp_a(la_o), .lamp_b(lb_o), .dbg_state(dbg_o));

    function automatic int next_of(int p, bit r, bit a, bit b);
        if (r) return 0;
        case (p)
            0: return a ? 0 : 1;
            1: return 2;
            2: return b ? 2 : 3;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int p, bit r, bit a);
        if (r) return "R1";
        case (p)
            0: return a ? "R3" : "R4";
            1: return "R5";
            2: return "R6/R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [1:0] exp_a(int p);
        case (p) 0: return 2'b00; 1: return 2'b01; default: return 2'b10; endcase
    endfunction

    function automatic logic [1:0] exp_b(int p);
        case (p) 2: return 2'b00; 3: return 2'b01; default: return 2'b10; endcase
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit r, bit a, bit b);
        string t;
        @(negedge clk);
        rst = r; sense_a = a; sense_b = b;
        t = tag_of(model, r, a);
        @(posedge clk);
        model = next_of(model, r, a, b);
        #2;
        check({t, " R9 lamp_a"}, {2'b00, la_b}, {2'b00, exp_a(model)});
        check({t, " R9 lamp_b"}, {2'b00, lb_b}, {2'b00, exp_b(model)});
        check("R10 binary dbg", dbg_b, 4'(model));
        check("R10 onehot dbg", dbg_o, 4'b0001 << model);
        check("R11 lamps match", {la_o, lb_o}, {la_b, lb_b});
        check("R2 no code 11", {2'b00, (la_b == 2'b11 || lb_b == 2'b11) ? 2'b11 : 2'b00}, 4'b0000);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; sense_a = 1'b0; sense_b = 1'b0;
        step(1, 0, 0);                  // R1 reset state
        step(1, 1, 1);
        // R3: A holds while busy, sense_b toggling has no effect
        step(0, 1, 0); step(0, 1, 1); step(0, 1, 0);
        // R4 then R5 with both sensors high
        step(0, 0, 1); step(0, 1, 1);
        // R6 with sense_a toggling, R7, R8 with sensors high
        step(0, 0, 1); step(0, 1, 1); step(0, 1, 0); step(0, 1, 1);
        // R1: reset during A warn beats the unconditional handover
        step(0, 0, 0); step(1, 1, 1);
        // R1: reset during B warn
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0); step(1, 0, 0);
        // R1: reset in B go with B busy
        step(0, 0, 1); step(0, 0, 1); step(1, 1, 1);
        // random run
        for (int i = 0; i < 3000; i++) begin
            bit r = ($urandom % 64) == 0;
            bit a = ($urandom % 4) != 0;
            bit b = ($urandom % 3) != 0;
            step(r, a, b);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule